// File: doc/BRIEF.md
# Paged Address Translator with Presence Check

This block turns a 32-bit virtual address into a physical address by looking up a page allocation table held on chip. The low 12 bits of the address are the offset within a page and pass through unchanged. The bits above them form the virtual page number, which selects one table entry directly. Each entry records whether the page currently sits in internal memory, the internal frame number used when it does, and the location of the page in external backing storage used when it does not.

A present page produces the frame number joined to the offset. An absent page produces a fault together with the external storage address of that page, so that a loader can fetch it. The loader then rewrites the entry through an update port. Each entry also carries a modified flag, set by any translated write to a present page. When the loader overwrites an entry that was present, the block reports whether that page was modified, so the loader knows whether the old contents must first be copied back to external storage. Pages go back to storage only when they are replaced, never on each write.

Top module: `page_xlate`

## Requirements
- R1: After reset no response and no eviction report is signalled, and every page is absent, so any in-range request faults until the loader marks a page present.
- R2: The virtual page number is address bits [31:12] and the in-page offset is bits [11:0]. In a successful translation, bits [11:0] of the physical address equal that offset.
- R3: A request to a present page returns rsp_fault=0, rsp_range=0, rsp_paddr = {frame, offset} and rsp_ext = 0.
- R4: A request to an absent in-range page returns rsp_fault=1, rsp_range=0, rsp_paddr = 0 and rsp_ext equal to the external address stored in that entry.
- R5: rsp_valid is high exactly one clock after a cycle with req_valid high and low otherwise. All response fields are zero while rsp_valid is low.
- R6: A table update takes effect for requests made on the next cycle or later. A request in the same cycle as an update to the same page sees the entry's previous contents.
- R7: A virtual page number at or above the table depth (PAGES, default 64) returns rsp_fault=1, rsp_range=1, rsp_paddr=0 and rsp_ext=0, and changes no table state.
- R8: A request with req_write=1 that hits a present page marks that page modified. Reads, and writes to absent or out-of-range pages, leave the modified flag unchanged. Any update of an entry clears the flag.
- R9: One clock after an update, evict_valid is 1 exactly when the updated page was present before the update, and evict_dirty then gives that page's modified flag. Both are 0 when the page was absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | Response available |
| rsp_fault | output | 1 | Page absent or out of range |
| rsp_range | output | 1 | Page number beyond the table |
| rsp_paddr | output | FRAME_W+12 (24) | Physical address on a hit |
| rsp_ext | output | EXT_W (16) | External address on an absent page |
| upd_valid | input | 1 | Table entry write |
| upd_page | input | log2(PAGES) (6) | Entry index to write |
| upd_present | input | 1 | New presence state |
| upd_frame | input | FRAME_W (12) | New internal frame number |
| upd_ext | input | EXT_W (16) | New external address |
| evict_valid | output | 1 | Updated entry had been present |
| evict_dirty | output | 1 | That page had been modified |

## Verification
Every translation result (rsp_valid, rsp_fault, rsp_range, rsp_paddr, rsp_ext) appears one clock after the request edge, and eviction reports appear one clock after the update edge. The bench drives inputs on the falling edge, holds them across one rising edge, and reads the outputs on the following falling edge, which falls in the single cycle in which they are due. The same-cycle update case applies the update and the request on one edge and expects the old entry. A second request then expects the new one.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  localparam int unsigned VA_W  = 32;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned VPN_W = VA_W - OFF_W;

  function automatic logic vpn_in_table(input logic [VPN_W-1:0] vpn,
                                        input int unsigned pages);
    return (vpn < pages);
  endfunction
endpackage

// File: rtl/pxl_table_ram.sv
module pxl_table_ram #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 28,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // read-first: a read in the write cycle returns the older word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pxl_flags.sv
module pxl_flags #(
  parameter int unsigned PAGES = 64,
  localparam int unsigned IW = $clog2(PAGES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_fire,
  input  logic          req_inrange,
  input  logic          req_write,
  input  logic [IW-1:0] req_idx,
  input  logic          upd_valid,
  input  logic [IW-1:0] upd_idx,
  input  logic          upd_present,
  output logic          pres_rd,
  output logic          evict_valid,
  output logic          evict_dirty
);
  logic [PAGES-1:0] pres_q;
  logic [PAGES-1:0] dirty_q;
  logic             mark_dirty;

  assign mark_dirty = req_fire && req_inrange && req_write && pres_q[req_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      pres_q      <= '0;
      dirty_q     <= '0;
      pres_rd     <= 1'b0;
      evict_valid <= 1'b0;
      evict_dirty <= 1'b0;
    end else begin
      if (req_fire) pres_rd <= pres_q[req_idx];
      evict_valid <= upd_valid && pres_q[upd_idx];
      evict_dirty <= upd_valid && pres_q[upd_idx] && dirty_q[upd_idx];
      if (mark_dirty) dirty_q[req_idx] <= 1'b1;
      // an update overrides a same-cycle write mark
      if (upd_valid) begin
        pres_q[upd_idx]  <= upd_present;
        dirty_q[upd_idx] <= 1'b0;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pres_q == '0 && dirty_q == '0 && !evict_valid));

  assert_dirty_set_R8: assert property (@(posedge clk) disable iff (rst)
    (mark_dirty && !(upd_valid && upd_idx == req_idx)) |=> dirty_q[$past(req_idx)]);

  assert_update_clears_R8: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> !dirty_q[$past(upd_idx)]);

  assert_evict_source_R9: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> $past(upd_valid));

  assert_evict_dirty_R9: assert property (@(posedge clk) disable iff (rst)
    evict_dirty |-> evict_valid);
endmodule

// File: rtl/pxl_resp.sv
module pxl_resp #(
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned EXT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_fire,
  input  logic                     req_inrange,
  input  logic [OFF_W-1:0]         req_off,
  input  logic                     pres_rd,
  input  logic [FRAME_W-1:0]       ram_frame,
  input  logic [EXT_W-1:0]         ram_ext,
  output logic                     rsp_valid,
  output logic                     rsp_fault,
  output logic                     rsp_range,
  output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
  output logic [EXT_W-1:0]         rsp_ext
);
  logic             v_q;
  logic             inr_q;
  logic [OFF_W-1:0] off_q;
  logic             hit;
  logic             miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      inr_q <= 1'b0;
      off_q <= '0;
    end else begin
      v_q <= req_fire;
      if (req_fire) begin
        inr_q <= req_inrange;
        off_q <= req_off;
      end
    end
  end

  assign hit  = v_q && inr_q && pres_rd;
  assign miss = v_q && inr_q && !pres_rd;

  assign rsp_valid = v_q;
  assign rsp_fault = v_q && !hit;
  assign rsp_range = v_q && !inr_q;
  assign rsp_paddr = hit  ? {ram_frame, off_q} : '0;
  assign rsp_ext   = miss ? ram_ext : '0;

  assert_range_faults_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_range |-> (rsp_fault && rsp_ext == '0 && rsp_paddr == '0));

  assert_quiet_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_fault && !rsp_range && rsp_paddr == '0 && rsp_ext == '0));
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import pxl_pkg::*;
#(
  parameter int unsigned PAGES   = 64,
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned EXT_W   = 16,
  localparam int unsigned IW     = $clog2(PAGES),
  localparam int unsigned PA_W   = FRAME_W + OFF_W,
  localparam int unsigned ENT_W  = FRAME_W + EXT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_write,
  output logic               rsp_valid,
  output logic               rsp_fault,
  output logic               rsp_range,
  output logic [PA_W-1:0]    rsp_paddr,
  output logic [EXT_W-1:0]   rsp_ext,
  input  logic               upd_valid,
  input  logic [IW-1:0]      upd_page,
  input  logic               upd_present,
  input  logic [FRAME_W-1:0] upd_frame,
  input  logic [EXT_W-1:0]   upd_ext,
  output logic               evict_valid,
  output logic               evict_dirty
);
  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] off;
  logic [IW-1:0]    idx;
  logic             inrange;
  logic             pres_rd;
  logic [ENT_W-1:0] ent_rd;

  assign vpn     = req_vaddr[VA_W-1:OFF_W];
  assign off     = req_vaddr[OFF_W-1:0];
  assign idx     = vpn[IW-1:0];
  assign inrange = vpn_in_table(vpn, PAGES);

  pxl_table_ram #(.DEPTH(PAGES), .WIDTH(ENT_W)) u_ram (
    .clk   (clk),
    .we    (upd_valid),
    .waddr (upd_page),
    .wdata ({upd_frame, upd_ext}),
    .re    (req_valid),
    .raddr (idx),
    .rdata (ent_rd)
  );

  pxl_flags #(.PAGES(PAGES)) u_flags (
    .clk         (clk),
    .rst         (rst),
    .req_fire    (req_valid),
    .req_inrange (inrange),
    .req_write   (req_write),
    .req_idx     (idx),
    .upd_valid   (upd_valid),
    .upd_idx     (upd_page),
    .upd_present (upd_present),
    .pres_rd     (pres_rd),
    .evict_valid (evict_valid),
    .evict_dirty (evict_dirty)
  );

  pxl_resp #(.OFF_W(OFF_W), .FRAME_W(FRAME_W), .EXT_W(EXT_W)) u_resp (
    .clk         (clk),
    .rst         (rst),
    .req_fire    (req_valid),
    .req_inrange (inrange),
    .req_off     (off),
    .pres_rd     (pres_rd),
    .ram_frame   (ent_rd[ENT_W-1:EXT_W]),
    .ram_ext     (ent_rd[EXT_W-1:0]),
    .rsp_valid   (rsp_valid),
    .rsp_fault   (rsp_fault),
    .rsp_range   (rsp_range),
    .rsp_paddr   (rsp_paddr),
    .rsp_ext     (rsp_ext)
  );

  assert_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  assert_out_of_table_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !inrange) |=> (rsp_fault && rsp_range));
endmodule

// File: tb/page_xlate_bench.sv
module page_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid, rsp_fault, rsp_range;
  logic [23:0] rsp_paddr;
  logic [15:0] rsp_ext;
  logic        upd_valid = 1'b0;
  logic [5:0]  upd_page = '0;
  logic        upd_present = 1'b0;
  logic [11:0] upd_frame = '0;
  logic [15:0] upd_ext = '0;
  logic        evict_valid, evict_dirty;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  page_xlate u_page_xlate (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_range(rsp_range),
    .rsp_paddr(rsp_paddr), .rsp_ext(rsp_ext),
    .upd_valid(upd_valid), .upd_page(upd_page), .upd_present(upd_present),
    .upd_frame(upd_frame), .upd_ext(upd_ext),
    .evict_valid(evict_valid), .evict_dirty(evict_dirty)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        flt;
    logic        rng;
    logic [23:0] pa;
    logic [15:0] ext;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0ABC, 1'b0, 1'b0, 1'b0, 24'h001ABC, 16'h0000},
    '{32'h0000_5678, 1'b0, 1'b0, 1'b0, 24'h3AB678, 16'h0000},
    '{32'h0003_FFFF, 1'b0, 1'b0, 1'b0, 24'hFFFFFF, 16'h0000},
    '{32'h0000_9123, 1'b0, 1'b1, 1'b0, 24'h000000, 16'hBEEF},
    '{32'h1234_5678, 1'b0, 1'b1, 1'b1, 24'h000000, 16'h0000},
    '{32'h0004_0000, 1'b0, 1'b1, 1'b1, 24'h000000, 16'h0000},
    '{32'h0000_A010, 1'b1, 1'b1, 1'b0, 24'h000000, 16'h0C0C}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [31:0] va, input logic wr);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_upd(input logic [5:0] pg, input logic pr,
                        input logic [11:0] fr, input logic [15:0] ex);
    @(negedge clk);
    upd_valid = 1'b1; upd_page = pg; upd_present = pr; upd_frame = fr; upd_ext = ex;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 evict_valid after reset", evict_valid, 0);
    do_req(32'h0000_0000, 1'b0);
    chk("R1 page absent after reset", rsp_fault, 1);
    chk("R1 not range", rsp_range, 0);

    do_upd(6'd0, 1'b1, 12'h001, 16'h0AAA);
    chk("R9 no evict from absent", evict_valid, 0);
    do_upd(6'd5, 1'b1, 12'h3AB, 16'h1234);
    do_upd(6'd9, 1'b0, 12'h000, 16'hBEEF);
    do_upd(6'd10, 1'b0, 12'h000, 16'h0C0C);
    do_upd(6'd63, 1'b1, 12'hFFF, 16'h7777);
    chk("R9 evict_dirty idle", evict_dirty, 0);

    // table walk: R2 R3 R4 R7
    for (int i = 0; i < NV; i++) begin
      do_req(VECS[i].va, VECS[i].wr);
      chk($sformatf("R5 valid vec%0d", i), rsp_valid, 1);
      chk($sformatf("R4 fault vec%0d", i), rsp_fault, VECS[i].flt);
      chk($sformatf("R7 range vec%0d", i), rsp_range, VECS[i].rng);
      chk($sformatf("R3 paddr vec%0d", i), rsp_paddr, VECS[i].pa);
      chk($sformatf("R4 ext vec%0d", i), rsp_ext, VECS[i].ext);
    end

    @(negedge clk);
    chk("R5 no response when idle", rsp_valid, 0);
    chk("R5 paddr zero when idle", rsp_paddr, 0);

    // R8 write to present page marks it modified
    do_req(32'h0000_5004, 1'b1);
    chk("R2 offset kept", rsp_paddr, 24'h3AB004);
    do_upd(6'd5, 1'b0, 12'h000, 16'h1234);
    chk("R9 evict on present page", evict_valid, 1);
    chk("R8 dirty after write", evict_dirty, 1);
    do_req(32'h0000_5004, 1'b0);
    chk("R4 evicted page faults", rsp_fault, 1);
    chk("R4 evicted page ext", rsp_ext, 16'h1234);

    // R8 reads do not mark
    do_req(32'h0003_F000, 1'b0);
    do_upd(6'd63, 1'b1, 12'h0F0, 16'h7777);
    chk("R9 evict on replace", evict_valid, 1);
    chk("R8 clean after read", evict_dirty, 0);
    do_req(32'h0003_F321, 1'b0);
    chk("R6 new frame used", rsp_paddr, 24'h0F0321);

    // R8 write to absent page (vec 6) did not mark; present then evict
    do_upd(6'd10, 1'b1, 12'h010, 16'h0C0C);
    chk("R9 no evict page10", evict_valid, 0);
    do_upd(6'd10, 1'b0, 12'h000, 16'h0C0C);
    chk("R9 evict page10", evict_valid, 1);
    chk("R8 absent write no mark", evict_dirty, 0);

    // R7 out-of-range write changes nothing: page 0 stays clean
    do_req(32'h0004_0000, 1'b1);
    do_upd(6'd0, 1'b1, 12'h001, 16'h0AAA);
    chk("R7 range write no mark", evict_dirty, 0);

    // R6 same-cycle update and request sees old entry
    @(negedge clk);
    upd_valid = 1'b1; upd_page = 6'd9; upd_present = 1'b1; upd_frame = 12'h222; upd_ext = 16'hBEEF;
    req_valid = 1'b1; req_vaddr = 32'h0000_9123; req_write = 1'b0;
    @(negedge clk);
    upd_valid = 1'b0; req_valid = 1'b0;
    chk("R6 same cycle old fault", rsp_fault, 1);
    chk("R6 same cycle old ext", rsp_ext, 16'hBEEF);
    do_req(32'h0000_9123, 1'b0);
    chk("R6 next cycle new fault", rsp_fault, 0);
    chk("R6 next cycle new paddr", rsp_paddr, 24'h222123);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule